// File: doc/BRIEF.md
# Channel Device Command Decoder

This block is the command front end of a peripheral that shares a processor I/O channel with other devices. Each I/O command arrives as two 16-bit words: an address word and a control word. The control word holds an area code, a three-bit function and an eight-bit modifier. The block compares the area code with the device's own strapped code. When they match, it answers the command. Sense-interrupt, sense-device and read commands put a word on the shared input bus. A write command captures the address word as data. A control command latches the modifier into a control register. An initiate command is handed to a separate block-transfer engine together with its word-count address.

The device keeps one pending interrupt condition for each channel level it uses. The usable levels are 2 to 5, and a parameter selects which of them the device uses. Each pending condition drives its own request line. A condition stays asserted until a sense-device command clears it through the modifier bits. The modifier bits are ranked from the device's highest-priority level downward. The input bus carries all zeros unless the device is answering, so the buses of several devices can be OR-combined.

Top module: `chan_dev_decoder`

## Requirements
- R1: After reset, `in_bus_o`, `irq_o`, `ctrl_o` and every strobe are zero.
- R2: A command whose area code (control word bits 0–4, vector bits [15:11]; bit 0 is the MSB) differs from `area_code_i` changes no output and no pending condition.
- R3: The function is taken from bits 5–7 (vector [10:8]). The codes are 001 write, 010 read, 011 sense interrupt, 100 control, 101 initiate write, 110 initiate read, 111 sense device. Code 000 has no effect.
- R4: A read drives `rd_data_i` onto `in_bus_o` for exactly the one cycle after the command, with a one-cycle `rd_ack_o`.
- R5: A write pulses `wr_stb_o` for one cycle, with `wr_data_o` equal to the address word.
- R6: A control command loads the modifier (bits 8–15, vector [7:0]) into `ctrl_o` and pulses `ctrl_stb_o`. At all other times `ctrl_o` holds its value.
- R7: An initiate command pulses `init_vld_o`, sets `init_rd_o` (1 = initiate read) and presents the address word on `init_wca_o` as the word-count address.
- R8: A sense interrupt drives a single bit onto the input bus, and only when the device has a condition pending on level `srv_level_i`. The bit's position (bit 0 = MSB) is set per level by the parameter `ILSW_POS`. With no pending condition on that level, the bus stays zero.
- R9: A sense device drives the device status word. Bits 0–3 (vector [15:12]) are the pending conditions of levels 2–5 in that order. Bits 4–15 are `dev_status_i`. The word shows the conditions as they were before any clear made by the same command.
- R10: In a sense device, modifier bit 15 clears the device's highest-priority enabled level, which is its lowest-numbered level. Bit 14 clears the next enabled level, and so on. Modifier bits beyond the number of enabled levels have no effect.
- R11: `cond_set_i[j]` makes level j+2 pending one cycle later, if that level is enabled in `LVL_MASK`. A pending level stays asserted on `irq_o[j]` until it is cleared. If a set and a clear arrive in the same cycle, the set wins.
- R12: `in_bus_o` is zero in every cycle that does not directly follow a selected read, sense-interrupt or sense-device command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| area_code_i | input | 5 | Strapped device area code |
| cmd_valid_i | input | 1 | Command words valid this cycle |
| iocc_ctl_i | input | 16 | Control word: area, function, modifier |
| iocc_addr_i | input | 16 | Address word (write data / word-count address) |
| srv_level_i | input | 3 | Interrupt level being serviced, for sense interrupt |
| rd_data_i | input | 16 | Device word returned by a read |
| dev_status_i | input | 12 | Device-specific status bits of the status word |
| cond_set_i | input | 4 | Raise condition on levels 2..5 |
| in_bus_o | output | 16 | Input-bus contribution, zero when idle |
| rd_ack_o | output | 1 | Read word taken |
| wr_stb_o | output | 1 | Write word valid |
| wr_data_o | output | 16 | Captured write word |
| ctrl_stb_o | output | 1 | Control register loaded |
| ctrl_o | output | 8 | Control register |
| init_vld_o | output | 1 | Initiate command for the transfer engine |
| init_rd_o | output | 1 | 1 = initiate read, 0 = initiate write |
| init_wca_o | output | 16 | Word-count address |
| irq_o | output | 4 | Request lines for levels 2..5 |

## Verification
The bench builds the block with `LVL_MASK = 4'b1101`, so levels 2, 4 and 5 are enabled and level 3 is not. It uses a different status-bit position for each level. The gap at level 3 makes modifier bits 15, 14 and 13 map to levels 2, 4 and 5, so the ranked clear cannot pass by mapping modifier bits to levels one-to-one. With a 5-bit area and a 3-bit function, the bench covers every area code, every function code, every serviced level from 0 to 7 and every clear pattern on the low four modifier bits.

// File: rtl/chan_dev_pkg.sv
package chan_dev_pkg;
  localparam int WORD_W   = 16;
  localparam int AREA_W   = 5;
  localparam int FUNC_W   = 3;
  localparam int MOD_W    = 8;
  localparam int NUM_LVL  = 4;
  localparam int LVL_BASE = 2;
  localparam int STAT_W   = WORD_W - NUM_LVL;
  localparam int LVL_W    = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_NONE      = 3'b000,
    FN_WRITE     = 3'b001,
    FN_READ      = 3'b010,
    FN_SENSE_INT = 3'b011,
    FN_CONTROL   = 3'b100,
    FN_INIT_WR   = 3'b101,
    FN_INIT_RD   = 3'b110,
    FN_SENSE_DEV = 3'b111
  } func_e;

  // first field lands in the MSBs: area = word bits 0-4
  typedef struct packed {
    logic [AREA_W-1:0] area;
    func_e             func;
    logic [MOD_W-1:0]  modif;
  } iocc_ctl_t;

  // position of level idx among enabled levels, counted from the highest priority
  function automatic int lvl_rank(logic [NUM_LVL-1:0] mask, int idx);
    int r;
    r = 0;
    for (int k = 0; k < NUM_LVL; k++)
      if (k < idx && mask[k]) r++;
    return r;
  endfunction

  // word bit numbering has bit 0 at the MSB
  function automatic logic [WORD_W-1:0] msb_bit(int pos);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1-pos] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/cdd_decode.sv
module cdd_decode
  import chan_dev_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [AREA_W-1:0] area_i,
  input  func_e             func_i,
  input  logic [AREA_W-1:0] area_code_i,
  output logic              do_write_o,
  output logic              do_read_o,
  output logic              do_sint_o,
  output logic              do_control_o,
  output logic              do_init_o,
  output logic              init_rd_o,
  output logic              do_sdev_o
);
  logic sel;
  assign sel = cmd_valid_i && (area_i == area_code_i);

  always_comb begin
    do_write_o   = 1'b0;
    do_read_o    = 1'b0;
    do_sint_o    = 1'b0;
    do_control_o = 1'b0;
    do_init_o    = 1'b0;
    init_rd_o    = 1'b0;
    do_sdev_o    = 1'b0;
    if (sel) begin
      unique case (func_i)
        FN_WRITE:     do_write_o   = 1'b1;
        FN_READ:      do_read_o    = 1'b1;
        FN_SENSE_INT: do_sint_o    = 1'b1;
        FN_CONTROL:   do_control_o = 1'b1;
        FN_INIT_WR:   do_init_o    = 1'b1;
        FN_INIT_RD: begin
          do_init_o = 1'b1;
          init_rd_o = 1'b1;
        end
        FN_SENSE_DEV: do_sdev_o    = 1'b1;
        default: ;
      endcase
    end
  end

  // R3: at most one action per command
  p_one_action_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({do_write_o, do_read_o, do_sint_o, do_control_o, do_init_o, do_sdev_o}));
  // R2: nothing decoded without a matching area
  p_area_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_write_o | do_read_o | do_sint_o | do_control_o | do_init_o | do_sdev_o)
      |-> (cmd_valid_i && area_i == area_code_i));
endmodule

// File: rtl/cdd_irq_bank.sv
module cdd_irq_bank
  import chan_dev_pkg::*;
#(
  parameter logic [NUM_LVL-1:0] LVL_MASK = 4'b1111
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] set_i,
  input  logic               clr_req_i,
  input  logic [NUM_LVL-1:0] clr_mod_i,
  output logic [NUM_LVL-1:0] pend_o
);
  logic [NUM_LVL-1:0] pend_q;
  logic [NUM_LVL-1:0] clr;

  for (genvar j = 0; j < NUM_LVL; j++) begin : g_lvl
    localparam int RANK = lvl_rank(LVL_MASK, j);

    assign clr[j] = clr_req_i & LVL_MASK[j] & clr_mod_i[RANK];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[j] <= 1'b0;
      else         pend_q[j] <= LVL_MASK[j] & (set_i[j] | (pend_q[j] & ~clr[j]));
    end

    // R11: a pending condition stays until cleared
    p_irq_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(pend_q[j]) && !$past(clr[j])) |-> pend_q[j]);
    // R11: a condition only rises after a set request
    p_irq_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[j]) |-> $past(set_i[j]));
    // R10: a clear without a set drops the level
    p_irq_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[j] && !set_i[j]) |=> !pend_q[j]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cdd_resp.sv
module cdd_resp
  import chan_dev_pkg::*;
#(
  parameter logic [NUM_LVL-1:0][3:0] ILSW_POS = {4'd3, 4'd2, 4'd1, 4'd0}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               do_write_i,
  input  logic               do_read_i,
  input  logic               do_sint_i,
  input  logic               do_control_i,
  input  logic               do_init_i,
  input  logic               init_rd_i,
  input  logic               do_sdev_i,
  input  logic [MOD_W-1:0]   modif_i,
  input  logic [WORD_W-1:0]  iocc_addr_i,
  input  logic [LVL_W-1:0]   srv_level_i,
  input  logic [WORD_W-1:0]  rd_data_i,
  input  logic [STAT_W-1:0]  dev_status_i,
  input  logic [NUM_LVL-1:0] pend_i,
  output logic [WORD_W-1:0]  in_bus_o,
  output logic               rd_ack_o,
  output logic               wr_stb_o,
  output logic [WORD_W-1:0]  wr_data_o,
  output logic               ctrl_stb_o,
  output logic [MOD_W-1:0]   ctrl_o,
  output logic               init_vld_o,
  output logic               init_rd_o,
  output logic [WORD_W-1:0]  init_wca_o
);
  logic [WORD_W-1:0] dsw;
  logic [WORD_W-1:0] ilsw;
  logic [WORD_W-1:0] bus_d;

  always_comb begin
    dsw = '0;
    dsw[STAT_W-1:0] = dev_status_i;
    for (int j = 0; j < NUM_LVL; j++) dsw[WORD_W-1-j] = pend_i[j];
  end

  always_comb begin
    ilsw = '0;
    for (int j = 0; j < NUM_LVL; j++)
      if (srv_level_i == LVL_W'(j + LVL_BASE) && pend_i[j])
        ilsw = ilsw | msb_bit(int'(ILSW_POS[j]));
  end

  always_comb begin
    bus_d = '0;
    if (do_read_i)      bus_d = rd_data_i;
    else if (do_sdev_i) bus_d = dsw;
    else if (do_sint_i) bus_d = ilsw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_bus_o   <= '0;
      rd_ack_o   <= 1'b0;
      wr_stb_o   <= 1'b0;
      wr_data_o  <= '0;
      ctrl_stb_o <= 1'b0;
      ctrl_o     <= '0;
      init_vld_o <= 1'b0;
      init_rd_o  <= 1'b0;
      init_wca_o <= '0;
    end else begin
      in_bus_o   <= bus_d;
      rd_ack_o   <= do_read_i;
      wr_stb_o   <= do_write_i;
      ctrl_stb_o <= do_control_i;
      init_vld_o <= do_init_i;
      if (do_write_i)   wr_data_o <= iocc_addr_i;
      if (do_control_i) ctrl_o    <= modif_i;
      if (do_init_i) begin
        init_rd_o  <= init_rd_i;
        init_wca_o <= iocc_addr_i;
      end
    end
  end

  p_bus_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_bus_o != '0) |-> $past(do_read_i | do_sdev_i | do_sint_i));
  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_ack_o, wr_stb_o, ctrl_stb_o, init_vld_o}));
  p_ctrl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_stb_o |-> $stable(ctrl_o));
  p_wr_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (wr_data_o == $past(iocc_addr_i)));
  p_read_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |-> (in_bus_o == $past(rd_data_i)));
  p_init_wca_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_vld_o |-> (init_wca_o == $past(iocc_addr_i)));
  p_sint_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(do_sint_i) |-> ($countones(in_bus_o) <= 1));
endmodule

// File: rtl/chan_dev_decoder.sv
module chan_dev_decoder
  import chan_dev_pkg::*;
#(
  parameter logic [NUM_LVL-1:0]      LVL_MASK = 4'b1111,
  parameter logic [NUM_LVL-1:0][3:0] ILSW_POS = {4'd3, 4'd2, 4'd1, 4'd0}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AREA_W-1:0]  area_code_i,
  input  logic               cmd_valid_i,
  input  logic [WORD_W-1:0]  iocc_ctl_i,
  input  logic [WORD_W-1:0]  iocc_addr_i,
  input  logic [LVL_W-1:0]   srv_level_i,
  input  logic [WORD_W-1:0]  rd_data_i,
  input  logic [STAT_W-1:0]  dev_status_i,
  input  logic [NUM_LVL-1:0] cond_set_i,
  output logic [WORD_W-1:0]  in_bus_o,
  output logic               rd_ack_o,
  output logic               wr_stb_o,
  output logic [WORD_W-1:0]  wr_data_o,
  output logic               ctrl_stb_o,
  output logic [MOD_W-1:0]   ctrl_o,
  output logic               init_vld_o,
  output logic               init_rd_o,
  output logic [WORD_W-1:0]  init_wca_o,
  output logic [NUM_LVL-1:0] irq_o
);
  iocc_ctl_t ctl;
  assign ctl = iocc_ctl_t'(iocc_ctl_i);

  logic do_write, do_read, do_sint, do_control, do_init, init_rd, do_sdev;
  logic [NUM_LVL-1:0] pend;

  cdd_decode u_decode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .area_i       (ctl.area),
    .func_i       (ctl.func),
    .area_code_i  (area_code_i),
    .do_write_o   (do_write),
    .do_read_o    (do_read),
    .do_sint_o    (do_sint),
    .do_control_o (do_control),
    .do_init_o    (do_init),
    .init_rd_o    (init_rd),
    .do_sdev_o    (do_sdev)
  );

  cdd_irq_bank #(.LVL_MASK(LVL_MASK)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (cond_set_i),
    .clr_req_i (do_sdev),
    .clr_mod_i (ctl.modif[NUM_LVL-1:0]),
    .pend_o    (pend)
  );

  cdd_resp #(.ILSW_POS(ILSW_POS)) u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .do_write_i   (do_write),
    .do_read_i    (do_read),
    .do_sint_i    (do_sint),
    .do_control_i (do_control),
    .do_init_i    (do_init),
    .init_rd_i    (init_rd),
    .do_sdev_i    (do_sdev),
    .modif_i      (ctl.modif),
    .iocc_addr_i  (iocc_addr_i),
    .srv_level_i  (srv_level_i),
    .rd_data_i    (rd_data_i),
    .dev_status_i (dev_status_i),
    .pend_i       (pend),
    .in_bus_o     (in_bus_o),
    .rd_ack_o     (rd_ack_o),
    .wr_stb_o     (wr_stb_o),
    .wr_data_o    (wr_data_o),
    .ctrl_stb_o   (ctrl_stb_o),
    .ctrl_o       (ctrl_o),
    .init_vld_o   (init_vld_o),
    .init_rd_o    (init_rd_o),
    .init_wca_o   (init_wca_o)
  );

  assign irq_o = pend;

  // R2: any response traces back to a command carrying this device's area code
  p_area_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_o | wr_stb_o | ctrl_stb_o | init_vld_o)
      |-> $past(cmd_valid_i && iocc_ctl_i[WORD_W-1 -: AREA_W] == area_code_i));
endmodule

// File: tb/tb_chan_dev_decoder.sv
module tb_chan_dev_decoder;
  localparam logic [3:0]      MASK = 4'b1101;
  localparam logic [3:0][3:0] POS  = {4'd12, 4'd7, 4'd0, 4'd3};
  localparam logic [4:0]      MY_AREA = 5'h13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  area_code = MY_AREA;
  logic        cmd_valid = 1'b0;
  logic [15:0] ctl_w = '0;
  logic [15:0] addr_w = '0;
  logic [2:0]  srv_level = '0;
  logic [15:0] rd_data = '0;
  logic [11:0] dev_status = '0;
  logic [3:0]  cond_set = '0;
  logic [15:0] in_bus, wr_data, init_wca;
  logic        rd_ack, wr_stb, ctrl_stb, init_vld, init_rd;
  logic [7:0]  ctrl;
  logic [3:0]  irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chan_dev_decoder #(.LVL_MASK(MASK), .ILSW_POS(POS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .area_code_i(area_code), .cmd_valid_i(cmd_valid),
    .iocc_ctl_i(ctl_w), .iocc_addr_i(addr_w), .srv_level_i(srv_level),
    .rd_data_i(rd_data), .dev_status_i(dev_status), .cond_set_i(cond_set),
    .in_bus_o(in_bus), .rd_ack_o(rd_ack), .wr_stb_o(wr_stb), .wr_data_o(wr_data),
    .ctrl_stb_o(ctrl_stb), .ctrl_o(ctrl), .init_vld_o(init_vld), .init_rd_o(init_rd),
    .init_wca_o(init_wca), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one command cycle; returns at the negedge after the capturing edge
  task automatic issue(logic [4:0] area, logic [2:0] fn, logic [7:0] md, logic [15:0] adr);
    @(negedge clk);
    cmd_valid = 1'b1;
    ctl_w = {area, fn, md};
    addr_w = adr;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic raise(logic [3:0] s);
    @(negedge clk);
    cond_set = s;
    @(negedge clk);
    cond_set = '0;
  endtask

  function automatic logic [15:0] exp_dsw(logic [3:0] p, logic [11:0] st);
    logic [15:0] w;
    w = {4'b0, st};
    for (int j = 0; j < 4; j++) w[15-j] = p[j];
    return w;
  endfunction

  // clear set per modifier, ranks counted over enabled levels from level 2 up
  function automatic logic [3:0] exp_clear(logic [7:0] md);
    logic [3:0] c;
    int r;
    c = '0;
    r = 0;
    for (int j = 0; j < 4; j++)
      if (MASK[j]) begin
        c[j] = md[r];
        r++;
      end
    return c;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] last_ctrl;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 bus", in_bus, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ctrl", ctrl, 0);
    chk("R1 strobes", {rd_ack, wr_stb, ctrl_stb, init_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R4: read across every area code
    for (int a = 0; a < 32; a++) begin
      rd_data = 16'hA500 ^ 16'(a * 16'h0111);
      issue(5'(a), 3'b010, 8'h00, 16'h0);
      chk("R4 R2 read bus", in_bus, (5'(a) == MY_AREA) ? rd_data : 16'h0);
      chk("R4 R2 read ack", rd_ack, (5'(a) == MY_AREA) ? 1 : 0);
      @(negedge clk);
      chk("R12 read bus drops", in_bus, 0);
      chk("R4 ack one cycle", rd_ack, 0);
    end

    // R3/R5/R6/R7: every function code, matching area
    last_ctrl = '0;
    for (int f = 0; f < 8; f++) begin
      logic [15:0] adr;
      logic [7:0]  md;
      adr = 16'h1234 + 16'(f * 16'h0F0F);
      md  = 8'(8'h5A ^ (f << 4));
      rd_data = 16'hBEEF;
      dev_status = 12'h000;
      issue(MY_AREA, 3'(f), (f == 7) ? 8'h00 : md, adr);
      chk("R3 write strobe", wr_stb, (f == 1) ? 1 : 0);
      if (f == 1) chk("R5 write data", wr_data, adr);
      chk("R3 read ack", rd_ack, (f == 2) ? 1 : 0);
      chk("R6 ctrl strobe", ctrl_stb, (f == 4) ? 1 : 0);
      if (f == 4) last_ctrl = md;
      chk("R6 ctrl value", ctrl, last_ctrl);
      chk("R7 init valid", init_vld, (f == 5 || f == 6) ? 1 : 0);
      if (f == 5 || f == 6) begin
        chk("R7 init dir", init_rd, (f == 6) ? 1 : 0);
        chk("R7 init wca", init_wca, adr);
      end
      chk("R12 R3 bus", in_bus, (f == 2) ? 16'hBEEF : 16'h0);
    end

    // R2: mismatched control leaves ctrl
    issue(MY_AREA ^ 5'h01, 3'b100, 8'hC3, 16'h0);
    chk("R2 ctrl kept", ctrl, last_ctrl);
    chk("R2 no strobe", ctrl_stb, 0);

    // R11: set all; level 3 disabled
    raise(4'hF);
    chk("R11 set", irq, MASK);
    repeat (3) @(negedge clk);
    chk("R11 held", irq, MASK);

    // R8: sweep serviced level
    for (int l = 0; l < 8; l++) begin
      logic [15:0] e;
      srv_level = 3'(l);
      e = '0;
      if (l >= 2 && l <= 5 && MASK[l-2]) e[15 - POS[l-2]] = 1'b1;
      issue(MY_AREA, 3'b011, 8'h00, 16'h0);
      chk("R8 ilsw", in_bus, e);
    end

    // R2: sense device with wrong area clears nothing
    issue(5'h00, 3'b111, 8'hFF, 16'h0);
    chk("R2 sdev ignored bus", in_bus, 0);
    chk("R2 sdev ignored irq", irq, MASK);

    // R9/R10: sweep clear patterns
    for (int m = 0; m < 16; m++) begin
      dev_status = 12'(12'hA5C ^ m);
      raise(4'hF);
      issue(MY_AREA, 3'b111, 8'(m), 16'h0);
      chk("R9 dsw", in_bus, exp_dsw(MASK, dev_status));
      chk("R10 clear", irq, MASK & ~exp_clear(8'(m)));
      srv_level = 3'd2;
      issue(MY_AREA, 3'b011, 8'h00, 16'h0);
      chk("R8 after clear", in_bus, (MASK[0] & ~exp_clear(8'(m))[0]) ? (16'h8000 >> POS[0]) : 16'h0);
    end

    // R11: set and clear together, set wins
    raise(4'hF);
    @(negedge clk);
    cmd_valid = 1'b1;
    ctl_w = {MY_AREA, 3'b111, 8'h07};
    cond_set = 4'b0001;
    @(negedge clk);
    cmd_valid = 1'b0;
    cond_set = '0;
    chk("R11 set wins", irq, 4'b0001);

    // R3: function 000 has no effect
    issue(MY_AREA, 3'b000, 8'hFF, 16'hFFFF);
    chk("R3 none bus", in_bus, 0);
    chk("R3 none strobes", {rd_ack, wr_stb, ctrl_stb, init_vld}, 0);
    chk("R3 none irq", irq, 4'b0001);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule